// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Periodic Refresh

This block takes a single-data-rate SDRAM from power-up to its operating state. It then keeps the array alive with periodic auto-refresh. After reset it drives a precharge of every bank, followed by a fixed run of auto-refresh commands spaced by the row-cycle time. Next it loads the mode register, placing a mode word on the address pins. That word is assembled from five static configuration inputs: burst length, burst type, CAS latency, operating mode and write-burst mode. When the mode-load settle time has passed, `init_done` goes high. From then on the block issues one auto-refresh each time the refresh interval runs out.

All waits are counted in clock cycles, and every timing figure is given in nanoseconds and converted from a clock-frequency parameter. The FSM states are: `S_RST` (reset hold), `S_PALL` (precharge all), `S_TRP` (precharge wait), `S_IREF` (initial refresh), `S_ITRC` (initial row-cycle wait), `S_LMR` (mode load), `S_TMRD` (mode-load wait), `S_IDLE` (operational), `S_REF` (periodic refresh) and `S_RTRC` (periodic row-cycle wait).

The transitions are:
- `S_RST`→`S_PALL` always.
- `S_PALL`→`S_TRP` always.
- `S_TRP`→`S_IREF` when the gap expires.
- `S_IREF`→`S_ITRC` always.
- `S_ITRC`→`S_IREF` on expiry while initial refreshes remain, and `S_ITRC`→`S_LMR` on expiry once all are done.
- `S_LMR`→`S_TMRD` always.
- `S_TMRD`→`S_IDLE` on expiry.
- `S_IDLE`→`S_REF` when a refresh is pending.
- `S_REF`→`S_RTRC` always.
- `S_RTRC`→`S_IDLE` on expiry.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, the command pins {cs_n,ras_n,cas_n,we_n} carry NOP (0111), `init_done` is 0 and the address and bank pins are 0.
- R2: In the first cycle after reset is released, the command is precharge (0010) with address bit 10 set, so that every bank is selected.
- R3: The first auto-refresh (0001) comes TRP_CYC cycles after the precharge, and no auto-refresh ever comes before a precharge.
- R4: During initialization exactly INIT_REFS auto-refresh commands are issued, each TRC_CYC cycles after the one before it.
- R5: The mode-load command (0000) comes TRC_CYC cycles after the last initial auto-refresh. In that cycle the bank pins are 0 and the address bits above bit 9 are 0.
- R6: During mode load the address pins carry the mode word: bits 2:0 burst length, bit 3 burst type, bits 6:4 CAS latency, bits 8:7 operating mode, bit 9 write-burst mode. Every code, reserved ones included, is passed through unchanged.
- R7: `init_done` rises TMRD_CYC cycles after the mode load and stays high until reset.
- R8: Every cycle that carries none of the commands above drives NOP, and every command is followed by at least one NOP.
- R9: In operation, an auto-refresh is issued REF_CYC cycles after the previous auto-refresh. The interval timer reloads on every auto-refresh, the initial ones included.
- R10: A refresh that falls due before `init_done` rises is held. It is issued in the cycle after `init_done` rises.
- R11: A reset asserted during operation clears `init_done` and restarts the whole sequence from the precharge.
- R12: TRP_CYC is ceil(TRP_NS·MHz/1000), with a minimum of 2. TRC_CYC is the larger of ceil(TRC_NS·MHz/1000) and ceil(TRAS_NS·MHz/1000)+TRP_CYC. REF_CYC is floor(REF_NS·MHz/1000), with a minimum of TRC_CYC+2. At 100 MHz with the defaults these give 2, 6 and 1562 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst-length code for mode word bits 2:0 |
| cfg_burst_type | input | 1 | Burst type for bit 3 (0 sequential, 1 interleaved) |
| cfg_cas_lat | input | 3 | CAS-latency code for bits 6:4 |
| cfg_op_mode | input | 2 | Operating-mode code for bits 8:7 |
| cfg_wr_single | input | 1 | Write-burst mode for bit 9 (1 single-location writes) |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank address, held at 0 |
| sd_addr | output | ADDR_W | SDRAM address bus |
| init_done | output | 1 | High once initialization is complete |

## Verification
The hardest case to reach is a refresh that falls due while initialization is still running and must be held until `init_done` rises. With realistic timing the interval is far longer than the whole power-up sequence, so this case never occurs. The bench therefore runs a second instance whose refresh interval is at its lower bound. In that instance the request arrives during the mode-load wait, and the bench expects the held refresh exactly one cycle after `init_done` rises. The mode word is swept over all 1024 field combinations, with a reset between runs. The first of those resets lands in the middle of periodic operation.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        S_RST, S_PALL, S_TRP, S_IREF, S_ITRC,
        S_LMR, S_TMRD, S_IDLE, S_REF, S_RTRC
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    localparam int MODE_W = 10;
    localparam int ALLBANK_BIT = 10;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdinit_ref_timer.sv
module sdinit_ref_timer #(
    parameter int REF_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_issue,
    output logic ref_pend
);
    localparam int W = $clog2(REF_CYC) + 1;

    logic [W-1:0] tmr;
    logic         armed;

    // Pending becomes visible REF_CYC-1 cycles after a refresh, so the FSM
    // can launch the next one exactly REF_CYC cycles after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr      <= '0;
            armed    <= 1'b0;
            ref_pend <= 1'b0;
        end else if (ref_issue) begin
            tmr      <= W'(REF_CYC - 1);
            armed    <= 1'b1;
            ref_pend <= 1'b0;
        end else if (armed) begin
            if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
            if (tmr == W'(2)) begin
                ref_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdinit_mode_word.sv
module sdinit_mode_word
    import sdinit_pkg::*;
(
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    input  logic [1:0]        op_mode,
    input  logic              wr_single,
    output logic [MODE_W-1:0] word
);
    always_comb begin
        word      = '0;
        word[2:0] = burst_len;
        word[3]   = burst_type;
        word[6:4] = cas_lat;
        word[8:7] = op_mode;
        word[9]   = wr_single;
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int TRP_NS    = 15,
    parameter int TRAS_NS   = 37,
    parameter int TRC_NS    = 60,
    parameter int TMRD_CYC  = 2,
    parameter int REF_NS    = 15625,
    parameter int INIT_REFS = 8,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_op_mode,
    input  logic              cfg_wr_single,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    localparam int TRP_RAW  = ceil_div(TRP_NS * CLK_MHZ, 1000);
    localparam int TRP_CYC  = imax(2, TRP_RAW);
    localparam int TRAS_CYC = ceil_div(TRAS_NS * CLK_MHZ, 1000);
    localparam int TRC_CYC  = imax(2, imax(ceil_div(TRC_NS * CLK_MHZ, 1000), TRAS_CYC + TRP_CYC));
    localparam int TMRD_EFF = imax(2, TMRD_CYC);
    localparam int REF_CYC  = imax((REF_NS * CLK_MHZ) / 1000, TRC_CYC + 2);
    localparam int GAP_MAX  = imax(TRP_CYC, imax(TRC_CYC, TMRD_EFF));
    localparam int GW       = $clog2(GAP_MAX) + 1;
    localparam int IW       = $clog2(INIT_REFS + 1);

    seq_state_e        state, nxt;
    sd_cmd_e           cmd;
    logic              gap_load;
    logic [GW-1:0]     gap_val;
    logic              gap_expired;
    logic              ref_issue;
    logic              ref_pend;
    logic [IW-1:0]     iref_cnt;
    logic [MODE_W-1:0] mode_word;

    sdinit_mode_word u_mode (
        .burst_len  (cfg_burst_len),
        .burst_type (cfg_burst_type),
        .cas_lat    (cfg_cas_lat),
        .op_mode    (cfg_op_mode),
        .wr_single  (cfg_wr_single),
        .word       (mode_word)
    );

    sdinit_gap_timer #(.W(GW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    sdinit_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_issue (ref_issue),
        .ref_pend  (ref_pend)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_RST;
        end else begin
            state <= nxt;
        end
    end

    // Initial refresh counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iref_cnt <= '0;
        end else if (state == S_IREF) begin
            iref_cnt <= iref_cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_RST:  nxt = S_PALL;
            S_PALL: nxt = S_TRP;
            S_TRP:  if (gap_expired) nxt = S_IREF;
            S_IREF: nxt = S_ITRC;
            S_ITRC: begin
                if (gap_expired) begin
                    nxt = (iref_cnt == IW'(INIT_REFS)) ? S_LMR : S_IREF;
                end
            end
            S_LMR:  nxt = S_TMRD;
            S_TMRD: if (gap_expired) nxt = S_IDLE;
            S_IDLE: if (ref_pend) nxt = S_REF;
            S_REF:  nxt = S_RTRC;
            S_RTRC: if (gap_expired) nxt = S_IDLE;
            default: nxt = S_RST;
        endcase
    end

    // Output logic
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        gap_load  = 1'b0;
        gap_val   = '0;
        ref_issue = 1'b0;
        init_done = 1'b0;
        unique case (state)
            S_PALL: begin
                cmd                  = CMD_PRE;
                sd_addr[ALLBANK_BIT] = 1'b1;
                gap_load             = 1'b1;
                gap_val              = GW'(TRP_CYC - 2);
            end
            S_IREF: begin
                cmd       = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GW'(TRC_CYC - 2);
                ref_issue = 1'b1;
            end
            S_LMR: begin
                cmd      = CMD_LMR;
                sd_addr  = {{(ADDR_W - MODE_W){1'b0}}, mode_word};
                gap_load = 1'b1;
                gap_val  = GW'(TMRD_EFF - 2);
            end
            S_IDLE: init_done = 1'b1;
            S_REF: begin
                cmd       = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GW'(TRC_CYC - 2);
                ref_issue = 1'b1;
                init_done = 1'b1;
            end
            S_RTRC: init_done = 1'b1;
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_ba = '0;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int INIT_REFS = 8,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_burst_len,
    input logic              cfg_burst_type,
    input logic [2:0]        cfg_cas_lat,
    input logic [1:0]        cfg_op_mode,
    input logic              cfg_wr_single,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    logic [3:0] pins;
    logic       pre_seen;
    int         refs_before;

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_seen    <= 1'b0;
            refs_before <= 0;
        end else begin
            if (pins == 4'b0010) pre_seen <= 1'b1;
            if (pins == 4'b0001 && !init_done && refs_before < INIT_REFS + 1)
                refs_before <= refs_before + 1;
        end
    end

    assert_pre_allbank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> sd_addr[10]);

    assert_ref_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0001) |-> pre_seen);

    assert_lmr_after_refs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (refs_before == INIT_REFS));

    assert_mode_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (sd_addr == ADDR_W'({cfg_wr_single, cfg_op_mode, cfg_cas_lat,
                                                     cfg_burst_type, cfg_burst_len})
                               && sd_ba == '0));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_nop_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != 4'b0111) |=> (pins == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .INIT_REFS (INIT_REFS),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_burst_len  (cfg_burst_len),
    .cfg_burst_type (cfg_burst_type),
    .cfg_cas_lat    (cfg_cas_lat),
    .cfg_op_mode    (cfg_op_mode),
    .cfg_wr_single  (cfg_wr_single),
    .sd_cs_n        (sd_cs_n),
    .sd_ras_n       (sd_ras_n),
    .sd_cas_n       (sd_cas_n),
    .sd_we_n        (sd_we_n),
    .sd_ba          (sd_ba),
    .sd_addr        (sd_addr),
    .init_done      (init_done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

    // Expected timing at 100 MHz, computed from R12
    localparam int E_TRP  = (15 * 100 + 999) / 1000;
    localparam int E_TRAS = (37 * 100 + 999) / 1000;
    localparam int E_TRC  = ((60 * 100 + 999) / 1000 > E_TRAS + E_TRP) ? (60 * 100 + 999) / 1000 : E_TRAS + E_TRP;
    localparam int E_TMRD = 2;
    localparam int E_REF  = (15625 * 100) / 1000;
    localparam int E_REFF = ((80 * 100) / 1000 > E_TRC + 2) ? (80 * 100) / 1000 : E_TRC + 2;
    localparam int NREF   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [2:0] bl = '0;
    logic       bt = 1'b0;
    logic [2:0] cl = '0;
    logic [1:0] om = '0;
    logic       ws = 1'b0;

    logic        d_cs, d_ras, d_cas, d_we, d_done;
    logic [1:0]  d_ba;
    logic [11:0] d_addr;
    logic        f_cs, f_ras, f_cas, f_we, f_done;
    logic [1:0]  f_ba;
    logic [11:0] f_addr;

    sdram_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cl), .cfg_op_mode(om), .cfg_wr_single(ws),
        .sd_cs_n(d_cs), .sd_ras_n(d_ras), .sd_cas_n(d_cas), .sd_we_n(d_we),
        .sd_ba(d_ba), .sd_addr(d_addr), .init_done(d_done)
    );

    sdram_init_seq #(.REF_NS(80)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_type(bt),
        .cfg_cas_lat(cl), .cfg_op_mode(om), .cfg_wr_single(ws),
        .sd_cs_n(f_cs), .sd_ras_n(f_ras), .sd_cas_n(f_cas), .sd_we_n(f_we),
        .sd_ba(f_ba), .sd_addr(f_addr), .init_done(f_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Event logs (non-NOP commands)
    int ev_cmd[0:31], ev_cyc[0:31], ev_addr[0:31], ev_ba[0:31];
    int n_ev = 0, done_cyc = -1;
    int fv_cmd[0:31], fv_cyc[0:31];
    int n_fv = 0, fdone_cyc = -1;

    always @(negedge clk) begin
        if (!rst_n) begin
            n_ev = 0; done_cyc = -1; n_fv = 0; fdone_cyc = -1;
        end else begin
            if ({d_cs, d_ras, d_cas, d_we} != 4'b0111) begin
                if (n_ev < 32) begin
                    ev_cmd[n_ev]  = int'({d_cs, d_ras, d_cas, d_we});
                    ev_cyc[n_ev]  = cyc;
                    ev_addr[n_ev] = int'(d_addr);
                    ev_ba[n_ev]   = int'(d_ba);
                end
                n_ev++;
            end
            if (d_done && done_cyc < 0) done_cyc = cyc;
            if ({f_cs, f_ras, f_cas, f_we} != 4'b0111) begin
                if (n_fv < 32) begin
                    fv_cmd[n_fv] = int'({f_cs, f_ras, f_cas, f_we});
                    fv_cyc[n_fv] = cyc;
                end
                n_fv++;
            end
            if (f_done && fdone_cyc < 0) fdone_cyc = cyc;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int rel;
        int exp_word;
        int first_post;
        // Phase A: one full run with a fixed mode word
        bl = 3'b010; bt = 1'b1; cl = 3'b011; om = 2'b00; ws = 1'b1;
        exp_word = 2 + 1 * 8 + 3 * 16 + 0 * 128 + 1 * 512;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1", "cmd in reset", int'({d_cs, d_ras, d_cas, d_we}), 7);
        check_eq("R1", "init_done in reset", int'(d_done), 0);
        check_eq("R1", "addr in reset", int'(d_addr), 0);
        check_eq("R1", "ba in reset", int'(d_ba), 0);
        rst_n = 1'b1;
        rel = cyc;
        repeat (4900) @(negedge clk);

        check_eq("R2", "first cmd", ev_cmd[0], 2);
        check_eq("R2", "first cmd cycle", ev_cyc[0], rel + 1);
        check_eq("R2", "all-bank bit", (ev_addr[0] >> 10) & 1, 1);
        check_eq("R3", "first refresh cmd", ev_cmd[1], 1);
        check_eq("R3", "precharge to refresh", ev_cyc[1] - ev_cyc[0], E_TRP);
        for (int k = 2; k <= NREF; k++) begin
            check_eq("R4", "init refresh cmd", ev_cmd[k], 1);
            check_eq("R4", "refresh spacing", ev_cyc[k] - ev_cyc[k-1], E_TRC);
        end
        check_eq("R5", "mode load cmd", ev_cmd[NREF+1], 0);
        check_eq("R5", "refresh to mode load", ev_cyc[NREF+1] - ev_cyc[NREF], E_TRC);
        check_eq("R5", "bank during mode load", ev_ba[NREF+1], 0);
        check_eq("R6", "mode word", ev_addr[NREF+1], exp_word);
        check_eq("R7", "mode load to done", done_cyc - ev_cyc[NREF+1], E_TMRD);
        check_eq("R7", "done still high", int'(d_done), 1);
        first_post = (ev_cyc[NREF] + E_REF > done_cyc + 1) ? ev_cyc[NREF] + E_REF : done_cyc + 1;
        check_eq("R9", "first periodic refresh cycle", ev_cyc[NREF+2], first_post);
        check_eq("R9", "periodic cmd", ev_cmd[NREF+3], 1);
        check_eq("R9", "periodic spacing 1", ev_cyc[NREF+3] - ev_cyc[NREF+2], E_REF);
        check_eq("R12", "periodic spacing 2", ev_cyc[NREF+4] - ev_cyc[NREF+3], E_REF);
        check_eq("R8", "command count", n_ev, NREF + 5);

        // Short-interval instance: refresh due during initialization
        check_eq("R4", "fast lmr index", fv_cmd[NREF+1], 0);
        check_eq("R10", "fast held refresh cmd", fv_cmd[NREF+2], 1);
        check_eq("R10", "held refresh after done", fv_cyc[NREF+2], fdone_cyc + 1);
        check_eq("R9", "fast spacing", fv_cyc[NREF+3] - fv_cyc[NREF+2], E_REFF);
        check_eq("R12", "fast spacing clamp", fv_cyc[NREF+4] - fv_cyc[NREF+3], E_REFF);

        // Phase B: exhaustive mode-word sweep; first reset hits live operation
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            bl = 3'(i & 7); bt = 1'((i >> 3) & 1); cl = 3'((i >> 4) & 7);
            om = 2'((i >> 7) & 3); ws = 1'((i >> 9) & 1);
            exp_word = (i & 7) + ((i >> 3) & 1) * 8 + ((i >> 4) & 7) * 16
                     + ((i >> 7) & 3) * 128 + ((i >> 9) & 1) * 512;
            rst_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            if (i == 0) check_eq("R11", "done cleared by reset", int'(d_done), 0);
            rst_n = 1'b1;
            rel = cyc;
            repeat (60) @(negedge clk);
            check_eq("R6", "sweep mode word", ev_addr[NREF+1], exp_word);
            if (i == 0) begin
                check_eq("R11", "restart precharge", ev_cmd[0], 2);
                check_eq("R11", "restart cycle", ev_cyc[0], rel + 1);
                check_eq("R11", "restart done", int'(d_done), 1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule